// File: doc/BRIEF.md
# Configurable Two-Table Logic Cell

This block is a programmable logic element. It holds two 16-entry lookup tables, each addressed by the low four cell inputs, plus a selector that can merge them. In split mode the cell gives two unrelated 4-input functions, one on each output. In fused mode, input 4 picks which table drives output A, so output A realises any 5-input function from a 32-entry truth table. Each output has its own flip-flop. A per-output option presents either the direct table result or the value that flip-flop captured at the last clock edge.

The configuration is volatile. A reset clears it, and the cell then stays dark until a fresh 35-bit configuration word has been shifted in serially. The serial port follows valid/ready rules. A bit is taken on a rising clock edge only when `cfg_valid` and `cfg_ready` are both high. `cfg_ready` stays high until the 35th bit has been taken, and then stays low until the next reset. While it is low, the sender is held off, and anything offered is dropped. Reconfiguring the cell therefore means reset followed by a reload.

Top module: `cfg_logic_cell`

## Requirements
- R1: While `rst_n` is low and just after it is released, `cfg_done` is 0, `cfg_ready` is 1, and both outputs are 0.
- R2: `cfg_done` rises on the clock edge that accepts the 35th configuration bit. It is still 0 after 34 bits. Once high, it stays high until reset.
- R3: Once `cfg_done` is high, `cfg_ready` is 0. Bits offered on `cfg_valid` are then ignored, and the functions seen on the outputs do not change.
- R4: While the configuration is incomplete, both outputs are 0 for every input value, and both flip-flops are held at 0.
- R5: The first accepted bit is the output B register select, followed by the output A register select, then the fuse bit (1 = fused). Next come the upper table entries 15 down to 0, and then the lower table entries 15 down to 0. A table entry's address bit 0 is `cell_in[0]`, and so on up to bit 3.
- R6: In split mode, output A gives lower_table[cell_in[3:0]], output B gives upper_table[cell_in[3:0]], and `cell_in[4]` has no effect.
- R7: In fused mode, output A gives upper_table[cell_in[3:0]] when `cell_in[4]` is 1 and lower_table[cell_in[3:0]] when it is 0. Output B gives upper_table[cell_in[3:0]].
- R8: An output whose register select is 0 follows the inputs within the same cycle.
- R9: An output whose register select is 1 shows the function value present at the previous rising clock edge.
- R10: A reset after a complete configuration returns the cell to the unconfigured state of R1 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell and configuration clock |
| rst_n | input | 1 | Active-low synchronous reset, clears the configuration |
| cfg_valid | input | 1 | Configuration bit offered |
| cfg_ready | output | 1 | Configuration bit can be taken (high until loaded) |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_done | output | 1 | Configuration complete |
| cell_in | input | 5 | Logic inputs; bits 3..0 address the tables, bit 4 is the fuse select |
| out_a | output | 1 | Output A (fused or lower-table function) |
| out_b | output | 1 | Output B (upper-table function) |

## Verification
The cell is loaded as a 5-input majority function in fused mode. This result differs from either table alone whenever input 4 decides the vote, so it shows that the merge select works. It is also loaded as a pair of 4-input parity functions, odd on output A and even on output B, in split mode. A single flipped table bit or address line changes parity, and an output that wrongly depends on input 4 shows up. Each load sweeps all 32 input values, with outputs compared against a behavioural model both before and after every input change. This separates a direct path from a registered one, because only the registered output still shows the old function value. A partial load, a load offered after completion, and a reset after completion confirm the gating and the volatility.

// File: rtl/cell_pkg.sv
package cell_pkg;
  localparam int unsigned CELL_K      = 4;
  localparam int unsigned CELL_TBL    = 1 << CELL_K;
  localparam int unsigned CELL_TABLES = 2;
  localparam int unsigned CELL_CFG_W  = CELL_TABLES * CELL_TBL + 3;

  typedef struct packed {
    logic                reg_b;
    logic                reg_a;
    logic                fused;
    logic [CELL_TBL-1:0] tbl_hi;
    logic [CELL_TBL-1:0] tbl_lo;
  } cell_cfg_t;
endpackage

// File: rtl/cell_cfg_chain.sv
module cell_cfg_chain
  import cell_pkg::*;
#(
  parameter int unsigned WORD_W = CELL_CFG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic              cfg_bit,
  output logic              cfg_ready,
  output logic              cfg_done,
  output logic [WORD_W-1:0] cfg_word
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0]  taken_q;
  logic [WORD_W-1:0] word_q;
  logic              accept;

  assign cfg_done  = (taken_q == CNT_FULL);
  assign cfg_ready = !cfg_done;
  assign accept    = cfg_valid && cfg_ready;
  assign cfg_word  = word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_q <= '0;
      word_q  <= '0;
    end else if (accept) begin
      taken_q <= taken_q + 1'b1;
      word_q  <= {word_q[WORD_W-2:0], cfg_bit};
    end
  end

  // R2: completion is sticky until reset
  p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> cfg_done);

  // R2: never counts past the word length
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    taken_q <= CNT_FULL);

  // R3: a complete configuration is frozen
  p_word_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> $stable(word_q));
endmodule

// File: rtl/cell_lut.sv
module cell_lut #(
  parameter int unsigned K = 4
) (
  input  logic [(1<<K)-1:0] table_bits,
  input  logic [K-1:0]      addr,
  output logic              y
);
  assign y = table_bits[addr];
endmodule

// File: rtl/cell_out_stage.sv
module cell_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic use_reg,
  input  logic func,
  output logic y
);
  logic ff_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !live) ff_q <= 1'b0;
    else                 ff_q <= func;
  end

  assign y = live ? (use_reg ? ff_q : func) : 1'b0;

  // R9: registered output shows the function from the previous edge
  p_reg_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(live) && use_reg) |-> (y == $past(func)));

  // R4: no output while unconfigured
  p_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> !y);
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
  import cell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic              cfg_bit,
  output logic              cfg_done,
  input  logic [CELL_K:0]   cell_in,
  output logic              out_a,
  output logic              out_b
);
  logic [CELL_CFG_W-1:0] word;
  cell_cfg_t             cfg;
  logic [CELL_TBL-1:0]   tbl  [CELL_TABLES];
  logic                  lut_y [CELL_TABLES];
  logic [1:0]            func;
  logic [1:0]            use_reg;
  logic [1:0]            y;

  cell_cfg_chain #(.WORD_W(CELL_CFG_W)) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_bit   (cfg_bit),
    .cfg_ready (cfg_ready),
    .cfg_done  (cfg_done),
    .cfg_word  (word)
  );

  assign cfg    = cell_cfg_t'(word);
  assign tbl[0] = cfg.tbl_lo;
  assign tbl[1] = cfg.tbl_hi;

  for (genvar t = 0; t < CELL_TABLES; t++) begin : g_tbl
    cell_lut #(.K(CELL_K)) u_lut (
      .table_bits (tbl[t]),
      .addr       (cell_in[CELL_K-1:0]),
      .y          (lut_y[t])
    );
  end

  always_comb begin
    func[0] = lut_y[0];
    if (cfg.fused && cell_in[CELL_K]) func[0] = lut_y[1];
    func[1] = lut_y[1];
  end

  assign use_reg = {cfg.reg_b, cfg.reg_a};

  for (genvar o = 0; o < 2; o++) begin : g_out
    cell_out_stage u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .live    (cfg_done),
      .use_reg (use_reg[o]),
      .func    (func[o]),
      .y       (y[o])
    );
  end

  assign out_a = y[0];
  assign out_b = y[1];

  // R7: fused direct output picks the table by input 4
  p_fused_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && cfg.fused && !cfg.reg_a) |->
      (out_a == (cell_in[CELL_K] ? lut_y[1] : lut_y[0])));

  // R3: ready and done are exclusive
  p_ready_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_ready && cfg_done));
endmodule

// File: tb/cfg_logic_cell_tb.sv
module cfg_logic_cell_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_valid = 1'b0;
  logic       cfg_bit = 1'b0;
  logic [4:0] cell_in = '0;
  logic       cfg_ready, cfg_done, out_a, out_b;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  cfg_logic_cell u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_bit(cfg_bit), .cfg_done(cfg_done), .cell_in(cell_in),
    .out_a(out_a), .out_b(out_b)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (in=%b t=%0t)", req, act, exp, cell_in, $time);
    end
  endtask

  // scenarios: 0 majority direct, 1 majority registered, 2 parity direct, 3 parity A registered
  function automatic logic ref_a(int s, logic [4:0] v);
    if (s < 2) return ($countones(v) >= 3);
    return ^v[3:0];
  endfunction
  function automatic logic ref_b(int s, logic [4:0] v);
    if (s < 2) return ($countones(v[3:0]) >= 2);
    return ~^v[3:0];
  endfunction
  function automatic logic reg_a_of(int s); return (s == 1 || s == 3); endfunction
  function automatic logic reg_b_of(int s); return (s == 1); endfunction

  // R5: word bit 34 is shifted first
  function automatic logic [34:0] word_of(int s);
    logic [15:0] lo, hi;
    for (int i = 0; i < 16; i++) begin
      lo[i] = ref_a(s, {1'b0, 4'(i)});
      hi[i] = (s < 2) ? ref_a(s, {1'b1, 4'(i)}) : ref_b(s, {1'b0, 4'(i)});
    end
    return {reg_b_of(s), reg_a_of(s), (s < 2), hi, lo};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cfg_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 done in reset", cfg_done, 1'b0);
    chk("R1 ready in reset", cfg_ready, 1'b1);
    chk("R1 out_a in reset", out_a, 1'b0);
    chk("R1 out_b in reset", out_b, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 done after release", cfg_done, 1'b0);
    chk("R1 ready after release", cfg_ready, 1'b1);
  endtask

  task automatic push(input logic [34:0] w, input int first, input int count);
    for (int i = first; i < first + count; i++) begin
      @(negedge clk); cfg_valid = 1'b1; cfg_bit = w[34-i];
    end
    @(negedge clk); cfg_valid = 1'b0;
    #1;
  endtask

  task automatic sweep(int s);
    logic [4:0] old;
    logic ea, eb;
    string ta, tb;
    ta = (s < 2) ? "R7" : "R6";
    tb = (s < 2) ? "R7" : "R6";
    for (int v = 0; v < 32; v++) begin
      @(negedge clk);
      chk({ta, " out_a settled"}, out_a, ref_a(s, cell_in));
      chk({tb, " out_b settled"}, out_b, ref_b(s, cell_in));
      old = cell_in;
      cell_in = 5'(v);
      #1;
      ea = reg_a_of(s) ? ref_a(s, old) : ref_a(s, cell_in);
      eb = reg_b_of(s) ? ref_b(s, old) : ref_b(s, cell_in);
      chk(reg_a_of(s) ? "R9 out_a holds previous" : "R8 out_a follows", out_a, ea);
      chk(reg_b_of(s) ? "R9 out_b holds previous" : "R8 out_b follows", out_b, eb);
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R4: partial load leaves cell dark
    push(word_of(0), 0, 20);
    for (int v = 0; v < 32; v++) begin
      @(negedge clk); cell_in = 5'(v); #1;
      chk("R4 out_a dark", out_a, 1'b0);
      chk("R4 out_b dark", out_b, 1'b0);
    end
    chk("R4 not done", cfg_done, 1'b0);

    for (int s = 0; s < 4; s++) begin
      do_reset();
      cell_in = '0;
      push(word_of(s), 0, 34);
      chk("R2 not done after 34", cfg_done, 1'b0);
      chk("R4 out_a before done", out_a, 1'b0);
      push(word_of(s), 34, 1);
      chk("R2 done after 35", cfg_done, 1'b1);
      chk("R3 ready low", cfg_ready, 1'b0);
      sweep(s);
      if (s == 0) begin
        push(~word_of(0), 0, 35);
        chk("R3 ready still low", cfg_ready, 1'b0);
        chk("R2 done sticky", cfg_done, 1'b1);
        sweep(0);
      end
    end

    // R10: reset after a full load returns to dark
    do_reset();
    for (int v = 0; v < 32; v += 7) begin
      @(negedge clk); cell_in = 5'(v); #1;
      chk("R10 out_a dark", out_a, 1'b0);
      chk("R10 out_b dark", out_b, 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule